// File: doc/BRIEF.md
# Condition Field Match Predicate Generator

This block walks a vector of condition fields and turns each one into a single predicate bit. Each field is 4 bits wide. It is compared bit by bit against a 4-bit pattern, and only the positions enabled by a 4-bit mask take part. The compare is reduced to one bit in one of two ways:

- **any-match:** at least one enabled position agrees with the pattern.
- **all-match:** every enabled position agrees with the pattern.

Each predicate bit is written into a 64-bit integer register file. The bits can either be packed into one scalar destination register, or spread eight per register across a run of destination registers.

A controller fires `start_i` with the following operands, which are latched on acceptance:
- the element count;
- the source field index and its vector/scalar flag;
- the destination register index and its vector/scalar flag;
- the mask and the pattern;
- the reduction mode;
- a map-reduce enable.

The block handles one element per clock. For each element it reads a condition field through a combinational read port. It updates the register file through a combinational read port and a write port on the same address, so each update is a read-modify-write. `done_o` pulses once when the walk has finished.

Top module: `cond_match_pred_gen`

## Requirements
- R1: For each element, the per-bit match vector is `n = ~(pattern ^ field) & mask`. A bit of `n` is set only where the field bit equals the pattern bit and the mask bit is 1.
- R2: With `any_mode_i` = 1, the element's predicate is 1 when any bit of `n` is 1. With a zero mask the predicate is therefore 0.
- R3: With `any_mode_i` = 0, the element's predicate is 1 when `n` equals the mask. With a zero mask the predicate is therefore 1.
- R4: With `src_vec_i` = 1, element i reads field `(src_idx + i) mod NUM_FIELDS`. With `src_vec_i` = 0, every element reads field `src_idx`.
- R5: With `dst_vec_i` = 0, element i writes register `dst_idx`. Arithmetic bit `i mod 64` (bit 0 = least significant) takes the predicate, and all other bits keep their prior value.
- R6: With `dst_vec_i` = 1, element i writes register `(dst_idx + i/8) mod NUM_REGS`.
  - Bits 63..8 are written as 0.
  - Bit `i mod 8` takes the predicate.
  - The other bits of 7..0 keep their prior value.
- R7: With `dst_vec_i` = 0 and `mr_en_i` = 0, only element 0 is written and the walk then ends, whatever the element count.
- R8: Timing of a walk:
  - The first write is in the cycle after `start_i` is sampled, with one write per cycle after that.
  - `done_o` is high for exactly one cycle, the cycle after the last write.
  - With an element count of 0 there are no writes, and `done_o` is high in the cycle after `start_i`.
- R9: `start_i` is ignored while a walk or its done cycle is in progress. The write stream, the registers written and the done cycle are all unaffected.
- R10: During reset and after it, `rf_we_o` and `done_o` are 0 until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a walk (sampled when idle) |
| vl_i | input | VL_W | Element count |
| src_idx_i | input | CF_AW | First condition field index |
| src_vec_i | input | 1 | 1: source index steps per element |
| dst_idx_i | input | RF_AW | First destination register index |
| dst_vec_i | input | 1 | 1: eight results per destination register |
| fmsk_i | input | 4 | Compare mask |
| fmap_i | input | 4 | Compare pattern |
| any_mode_i | input | 1 | 1: any-match, 0: all-match |
| mr_en_i | input | 1 | Map-reduce enable (scalar destination continues) |
| cf_raddr_o | output | CF_AW | Condition field read address |
| cf_rdata_i | input | 4 | Condition field read data (combinational) |
| rf_addr_o | output | RF_AW | Register file read/write address |
| rf_rdata_i | input | XLEN | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_wdata_o | output | XLEN | Register file write data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The match and reduction stage is driven with zero, full and partial masks in both reduction modes. This separates an inverted or swapped compare from a wrong reduction, and it makes the empty-mask outcome differ between the two modes.

The source is tried both stepping and fixed, and the destination both scalar and vector, including a vector run that wraps past the last register. These patterns show up addressing and bit-placement faults, and whether the upper-bit clear is applied.

Scalar walks with map-reduce off and with a full 64-element count check the early exit. A count of 0 and a start pulse injected mid-walk check the done timing and that starts are ignored while busy.

// File: rtl/cmpg_pkg.sv
package cmpg_pkg;
  localparam int unsigned FW = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } cmpg_state_e;
endpackage

// File: rtl/cmpg_match.sv
module cmpg_match
  import cmpg_pkg::*;
(
  input  logic [FW-1:0] field_i,
  input  logic [FW-1:0] fmap_i,
  input  logic [FW-1:0] fmsk_i,
  input  logic          any_mode_i,
  output logic          pred_o
);
  logic [FW-1:0] hit;

  always_comb begin
    hit    = ~(fmap_i ^ field_i) & fmsk_i;
    pred_o = any_mode_i ? (|hit) : (hit == fmsk_i);
  end
endmodule

// File: rtl/cmpg_seq.sv
module cmpg_seq
  import cmpg_pkg::*;
#(
  parameter int unsigned VL_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            vl_zero_i,
  input  logic            last_i,
  output logic            accept_o,
  output logic            run_o,
  output logic            fin_o,
  output logic [VL_W-1:0] idx_o
);
  cmpg_state_e state_q, state_d;
  logic [VL_W-1:0] idx_q, idx_d;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign run_o    = (state_q == ST_RUN);
  assign fin_o    = (state_q == ST_FIN);
  assign idx_o    = idx_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          idx_d   = '0;
          state_d = vl_zero_i ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        if (last_i) state_d = ST_FIN;
        else        idx_d   = idx_q + VL_W'(1);
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/cmpg_place.sv
module cmpg_place #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned RF_AW = 5,
  parameter int unsigned VL_W  = 7,
  parameter int unsigned PACK  = 8
) (
  input  logic [VL_W-1:0]  idx_i,
  input  logic [RF_AW-1:0] rt_i,
  input  logic             dst_vec_i,
  input  logic             pred_i,
  input  logic [XLEN-1:0]  rdata_i,
  output logic [RF_AW-1:0] addr_o,
  output logic [XLEN-1:0]  wdata_o
);
  localparam int unsigned XB = $clog2(XLEN);
  localparam int unsigned PB = $clog2(PACK);

  logic [VL_W-1:0] grp;
  logic [XB-1:0]   sbit;
  logic [PB-1:0]   vbit;

  assign grp  = idx_i >> PB;
  assign sbit = idx_i[XB-1:0];
  assign vbit = idx_i[PB-1:0];

  always_comb begin
    if (dst_vec_i) begin
      addr_o              = rt_i + RF_AW'(grp);
      wdata_o             = '0;
      wdata_o[PACK-1:0]   = rdata_i[PACK-1:0];
      wdata_o[vbit]       = pred_i;
    end else begin
      addr_o              = rt_i;
      wdata_o             = rdata_i;
      wdata_o[sbit]       = pred_i;
    end
  end
endmodule

// File: rtl/cond_match_pred_gen.sv
module cond_match_pred_gen
  import cmpg_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = 64,
  parameter int unsigned NUM_REGS   = 32,
  parameter int unsigned XLEN       = 64,
  parameter int unsigned VL_W       = 7,
  parameter int unsigned PACK       = 8,
  localparam int unsigned CF_AW     = $clog2(NUM_FIELDS),
  localparam int unsigned RF_AW     = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [CF_AW-1:0] src_idx_i,
  input  logic             src_vec_i,
  input  logic [RF_AW-1:0] dst_idx_i,
  input  logic             dst_vec_i,
  input  logic [FW-1:0]    fmsk_i,
  input  logic [FW-1:0]    fmap_i,
  input  logic             any_mode_i,
  input  logic             mr_en_i,
  output logic [CF_AW-1:0] cf_raddr_o,
  input  logic [FW-1:0]    cf_rdata_i,
  output logic [RF_AW-1:0] rf_addr_o,
  input  logic [XLEN-1:0]  rf_rdata_i,
  output logic             rf_we_o,
  output logic [XLEN-1:0]  rf_wdata_o,
  output logic             done_o
);
  // latched operands
  logic [VL_W-1:0]  vl_q;
  logic [CF_AW-1:0] bb_q;
  logic             src_vec_q;
  logic [RF_AW-1:0] rt_q;
  logic             dst_vec_q;
  logic [FW-1:0]    fmsk_q;
  logic [FW-1:0]    fmap_q;
  logic             any_q;
  logic             mr_q;

  logic            accept, run, fin, last, pred;
  logic [VL_W-1:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q      <= '0;
      bb_q      <= '0;
      src_vec_q <= 1'b0;
      rt_q      <= '0;
      dst_vec_q <= 1'b0;
      fmsk_q    <= '0;
      fmap_q    <= '0;
      any_q     <= 1'b0;
      mr_q      <= 1'b0;
    end else if (accept) begin
      vl_q      <= vl_i;
      bb_q      <= src_idx_i;
      src_vec_q <= src_vec_i;
      rt_q      <= dst_idx_i;
      dst_vec_q <= dst_vec_i;
      fmsk_q    <= fmsk_i;
      fmap_q    <= fmap_i;
      any_q     <= any_mode_i;
      mr_q      <= mr_en_i;
    end
  end

  // scalar destination without map-reduce stops after element 0
  assign last = (idx == vl_q - VL_W'(1)) || (!dst_vec_q && !mr_q);

  cmpg_seq #(.VL_W(VL_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .vl_zero_i (vl_i == '0),
    .last_i    (last),
    .accept_o  (accept),
    .run_o     (run),
    .fin_o     (fin),
    .idx_o     (idx)
  );

  assign cf_raddr_o = src_vec_q ? (bb_q + CF_AW'(idx)) : bb_q;

  cmpg_match u_match (
    .field_i    (cf_rdata_i),
    .fmap_i     (fmap_q),
    .fmsk_i     (fmsk_q),
    .any_mode_i (any_q),
    .pred_o     (pred)
  );

  cmpg_place #(
    .XLEN  (XLEN),
    .RF_AW (RF_AW),
    .VL_W  (VL_W),
    .PACK  (PACK)
  ) u_place (
    .idx_i     (idx),
    .rt_i      (rt_q),
    .dst_vec_i (dst_vec_q),
    .pred_i    (pred),
    .rdata_i   (rf_rdata_i),
    .addr_o    (rf_addr_o),
    .wdata_o   (rf_wdata_o)
  );

  assign rf_we_o = run;
  assign done_o  = fin;
endmodule

// File: rtl/cmpg_checker.sv
module cmpg_checker #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned PACK  = 8,
  parameter int unsigned CF_AW = 6,
  parameter int unsigned RF_AW = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             rf_we_o,
  input logic             done_o,
  input logic [RF_AW-1:0] rf_addr_o,
  input logic [XLEN-1:0]  rf_wdata_o,
  input logic [CF_AW-1:0] cf_raddr_o,
  input logic             src_vec_q,
  input logic             dst_vec_q,
  input logic             mr_q,
  input logic [CF_AW-1:0] bb_q,
  input logic [RF_AW-1:0] rt_q
);
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rf_we_o && done_o));

  a_r8_done_after_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rf_we_o) |-> done_o);

  a_r8_first_write_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rf_we_o) |-> $past(start_i));

  a_r7_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && !dst_vec_q && !mr_q) |=> !rf_we_o);

  a_r5_scalar_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && !dst_vec_q) |-> (rf_addr_o == rt_q));

  a_r4_scalar_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && !src_vec_q) |-> (cf_raddr_o == bb_q));

  a_r6_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && dst_vec_q) |-> (rf_wdata_o[XLEN-1:PACK] == '0));

  a_r9_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && $past(rf_we_o)) |-> ($stable(rt_q) && $stable(dst_vec_q)));
endmodule

bind cond_match_pred_gen cmpg_checker #(
  .XLEN  (XLEN),
  .PACK  (PACK),
  .CF_AW (CF_AW),
  .RF_AW (RF_AW)
) u_cmpg_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .rf_we_o    (rf_we_o),
  .done_o     (done_o),
  .rf_addr_o  (rf_addr_o),
  .rf_wdata_o (rf_wdata_o),
  .cf_raddr_o (cf_raddr_o),
  .src_vec_q  (src_vec_q),
  .dst_vec_q  (dst_vec_q),
  .mr_q       (mr_q),
  .bb_q       (bb_q),
  .rt_q       (rt_q)
);

// File: tb/cond_match_pred_gen_tb_top.sv
module cond_match_pred_gen_tb_top;
  localparam int NF = 64;
  localparam int NR = 32;
  localparam int XL = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl = '0;
  logic [5:0]  src_idx = '0;
  logic        src_vec = 1'b0;
  logic [4:0]  dst_idx = '0;
  logic        dst_vec = 1'b0;
  logic [3:0]  fmsk = '0, fmap = '0;
  logic        any_mode = 1'b0, mr_en = 1'b0;
  logic [5:0]  cf_raddr;
  logic [3:0]  cf_rdata;
  logic [4:0]  rf_addr;
  logic [63:0] rf_rdata, rf_wdata;
  logic        rf_we, done;

  logic [3:0]  cf_mem [NF];
  logic [63:0] rf_mem [NR];
  logic [63:0] ref_rf [NR];

  bit          exp_done_q [$];
  logic [4:0]  exp_addr_q [$];
  logic [63:0] exp_data_q [$];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cond_match_pred_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl),
    .src_idx_i(src_idx), .src_vec_i(src_vec), .dst_idx_i(dst_idx),
    .dst_vec_i(dst_vec), .fmsk_i(fmsk), .fmap_i(fmap),
    .any_mode_i(any_mode), .mr_en_i(mr_en), .cf_raddr_o(cf_raddr),
    .cf_rdata_i(cf_rdata), .rf_addr_o(rf_addr), .rf_rdata_i(rf_rdata),
    .rf_we_o(rf_we), .rf_wdata_o(rf_wdata), .done_o(done)
  );

  assign cf_rdata = cf_mem[cf_raddr];
  assign rf_rdata = rf_mem[rf_addr];

  always @(posedge clk) if (rf_we) rf_mem[rf_addr] <= rf_wdata;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference: list of expected write/done events
  task automatic model(int n, int bb, bit sv, int rt, bit dv,
                       logic [3:0] msk, logic [3:0] map, bit m, bit mr);
    for (int i = 0; i < n; i++) begin
      logic [3:0]  f, hit;
      logic        r;
      int          a;
      logic [63:0] d;
      f   = cf_mem[sv ? (bb + i) % NF : bb];
      hit = 4'd0;
      for (int b = 0; b < 4; b++) hit[b] = msk[b] && (map[b] == f[b]);
      if (m) r = (hit != 4'd0);
      else   r = (hit == msk);
      if (dv) begin
        a = (rt + i / 8) % NR;
        d = ref_rf[a];
        d[63:8] = '0;
        d[i % 8] = r;
      end else begin
        a = rt;
        d = ref_rf[a];
        d[i % 64] = r;
      end
      ref_rf[a] = d;
      exp_done_q.push_back(1'b0);
      exp_addr_q.push_back(a[4:0]);
      exp_data_q.push_back(d);
      if (!dv && !mr) break;
    end
    exp_done_q.push_back(1'b1);
    exp_addr_q.push_back('0);
    exp_data_q.push_back('0);
  endtask

  task automatic run_op(int n, int bb, bit sv, int rt, bit dv,
                        logic [3:0] msk, logic [3:0] map, bit m, bit mr,
                        bit bump, string dtag);
    string atag;
    atag = dv ? "R6" : "R5";
    @(negedge clk);
    vl = 7'(n); src_idx = 6'(bb); src_vec = sv; dst_idx = 5'(rt);
    dst_vec = dv; fmsk = msk; fmap = map; any_mode = m; mr_en = mr;
    start = 1'b1;
    model(n, bb, sv, rt, dv, msk, map, m, mr);
    for (int cyc = 0; cyc < 200; cyc++) begin
      bit ed;
      logic [4:0] ea;
      logic [63:0] edat;
      @(negedge clk);
      start = 1'b0;
      if (bump && cyc == 1) begin
        // R9: foreign start mid-walk with different operands
        start = 1'b1; vl = 7'd5; dst_idx = dst_idx + 5'd3; dst_vec = ~dst_vec;
        fmsk = ~fmsk; any_mode = ~any_mode; mr_en = 1'b1;
      end
      if (bump && cyc == 2) start = 1'b0;
      ed = exp_done_q.pop_front();
      ea = exp_addr_q.pop_front();
      edat = exp_data_q.pop_front();
      if (ed) begin
        chk(done === 1'b1 && rf_we === 1'b0, "R8", {62'd0, rf_we, done}, 64'd1);
        break;
      end else begin
        chk(rf_we === 1'b1 && done === 1'b0, "R8", {62'd0, rf_we, done}, 64'd2);
        chk(rf_addr === ea, atag, 64'(rf_addr), 64'(ea));
        chk(rf_wdata === edat, dtag, rf_wdata, edat);
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(rf_we === 1'b0 && done === 1'b0, "R8", {62'd0, rf_we, done}, 64'd0);
    for (int r = 0; r < NR; r++)
      if (rf_mem[r] !== ref_rf[r]) chk(1'b0, atag, rf_mem[r], ref_rf[r]);
    checks++;
  endtask

  initial begin
    for (int i = 0; i < NF; i++) cf_mem[i] = 4'((i * 7 + 3) ^ (i >> 2));
    for (int r = 0; r < NR; r++) begin
      rf_mem[r] = {32'(r * 32'h9e3779b9), 32'(~(r * 32'h85ebca6b))};
      ref_rf[r] = rf_mem[r];
    end
    repeat (3) @(negedge clk);
    chk(rf_we === 1'b0 && done === 1'b0, "R10", {62'd0, rf_we, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rf_we === 1'b0 && done === 1'b0, "R10", {62'd0, rf_we, done}, 64'd0);

    // R8: zero count
    run_op(0, 5, 1, 2, 1, 4'hF, 4'h3, 1, 1, 0, "R8");
    // R7: scalar destination, map-reduce off, long count
    run_op(20, 9, 1, 4, 0, 4'hF, 4'h6, 0, 0, 0, "R7");
    // R2 / R4 / R5: full scalar walk, any-match, partial mask
    run_op(64, 1, 1, 7, 0, 4'b1010, 4'b1000, 1, 1, 0, "R2");
    // R3: zero mask all-match gives 1, scalar source
    run_op(10, 11, 0, 8, 0, 4'h0, 4'h5, 0, 1, 0, "R3");
    // R2: zero mask any-match gives 0
    run_op(10, 11, 0, 9, 0, 4'h0, 4'h5, 1, 1, 0, "R2");
    // R1 / R3: full mask all-match, vector destination
    run_op(20, 0, 1, 12, 1, 4'hF, 4'h9, 0, 0, 0, "R1");
    // R6: vector destination wrapping past the last register
    run_op(24, 40, 1, 30, 1, 4'b0110, 4'b0100, 1, 0, 0, "R6");
    // R9: start pulsed during the walk
    run_op(12, 3, 1, 16, 1, 4'b1100, 4'b0100, 0, 0, 1, "R9");
    run_op(1, 3, 1, 20, 0, 4'b0011, 4'b0001, 1, 0, 1, "R9");

    for (int k = 0; k < 30; k++) begin
      bit dv, mr;
      int n;
      dv = 1'($urandom);
      mr = 1'($urandom);
      n  = dv ? int'($urandom_range(0, 100)) : int'($urandom_range(0, 64));
      run_op(n, int'($urandom_range(0, 63)), 1'($urandom), int'($urandom_range(0, 31)),
             dv, 4'($urandom), 4'($urandom), 1'($urandom), mr, 1'($urandom) && n > 0, "R1");
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule